// File: doc/BRIEF.md
# Multi-Bit Flip-Flop Resynchronizer

This block carries a bus of level signals into a destination clock domain. It passes the bus through a chain of flip-flops clocked by the destination clock. Metastability that the first stage may capture settles before the value reaches the output. Each bit travels in its own independent chain. The block does not keep a multi-bit value coherent: a bus that changes while it is being sampled can show a mix of old and new bits for a cycle. Coherent transfer of a bus is left to the logic around the block, for example Gray-coded counters or a handshake.

Every stage has a power-up value set by a parameter. By default the chain has no reset at all and only starts from that value. A parameter can make the chain resettable instead. In that mode the synchronous, active-high destination reset forces every stage to the same value, and no other reset reaches the chain.

Top module: `mbit_resync`

## Requirements
- R1: The chain has `DEPTH` stages (`DEPTH` >= 2) of `WIDTH` flip-flops each, all clocked by `clk_dst`. The output `q_dst` is driven directly by the last stage.
- R2: On every `clk_dst` edge at which no reset is applied, each stage takes the value of the stage before it, and the first stage takes `d_async`. A change on a steady input therefore reaches `q_dst` after exactly `DEPTH` edges, and not one edge sooner.
- R3: At power-up, before the first clock edge, every stage holds `START_VAL` and `q_dst` equals `START_VAL`, in both reset modes.
- R4: With `NO_RESET` = 1 (the default), `rst_dst` has no effect: `q_dst` keeps following `d_async` with a delay of `DEPTH` edges whether `rst_dst` is high or low.
- R5: With `NO_RESET` = 0, every `clk_dst` edge at which `rst_dst` is high loads `START_VAL` into all stages, so `q_dst` equals `START_VAL` from the first such edge until the reset is released.
- R6: With `NO_RESET` = 0, after `rst_dst` falls `q_dst` stays at `START_VAL` for `DEPTH`-1 edges and shows the held input at the `DEPTH`-th edge.
- R7: Each bit position is carried independently. Every one of the 2^`WIDTH` input codes arrives at `q_dst` unchanged, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dst | input | 1 | Destination-domain clock |
| rst_dst | input | 1 | Destination-domain synchronous active-high reset; used only when `NO_RESET` = 0 |
| d_async | input | WIDTH | Level bus from the source domain |
| q_dst | output | WIDTH | Resynchronized bus, driven by the last stage |

## Verification
The bench builds two instances with `WIDTH` = 4, `DEPTH` = 3 and `START_VAL` = 4'hA. One keeps the default reset-less chain and the other uses the resettable chain. The small width lets the bench sweep all sixteen input codes through both instances. At each code it confirms that `q_dst` still holds the previous code for two edges and shows the new one at the third. Because `START_VAL` differs from the codes used in the reset scenarios, the bench can tell a cleared chain from one that still carries data. Driving the same reset pulse into both instances shows in the same cycles that one chain ignores it and the other is cleared and then refilled.

// File: rtl/mbit_resync_pkg.sv
package mbit_resync_pkg;

  typedef enum logic {
    CLR_NONE = 1'b0,
    CLR_SYNC = 1'b1
  } clr_mode_e;

  function automatic clr_mode_e mode_from_flag(input bit no_reset);
    return no_reset ? CLR_NONE : CLR_SYNC;
  endfunction

endpackage

// File: rtl/mbit_resync_stage.sv
module mbit_resync_stage
  import mbit_resync_pkg::*;
#(
  parameter int        WIDTH     = 4,
  parameter logic [WIDTH-1:0] START_VAL = '0,
  parameter clr_mode_e MODE      = CLR_NONE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] flop_r = START_VAL;

  generate
    if (MODE == CLR_SYNC) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst) flop_r <= START_VAL;
        else     flop_r <= d;
      end
    end else begin : g_free
      always_ff @(posedge clk) begin
        flop_r <= d;
      end
    end
  endgenerate

  assign q = flop_r;

  // Assertion guard: true once a first edge has been seen.
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  generate
    if (MODE == CLR_SYNC) begin : g_chk_clr
      // R2: with no reset applied, the stage copies its input
      p_shift_r2: assert property (@(posedge clk) disable iff (!primed)
        !rst |=> q == $past(d));
      // R5: a reset edge loads the start value
      p_hold_start_r5: assert property (@(posedge clk) disable iff (!primed)
        rst |=> q == START_VAL);
    end else begin : g_chk_free
      // R4: the reset input makes no difference to the stage
      p_ignore_rst_r4: assert property (@(posedge clk) disable iff (!primed)
        rst |=> q == $past(d));
      // R2: the stage copies its input on every edge
      p_shift_r2: assert property (@(posedge clk) disable iff (!primed)
        !rst |=> q == $past(d));
    end
  endgenerate

endmodule

// File: rtl/mbit_resync_chain.sv
module mbit_resync_chain
  import mbit_resync_pkg::*;
#(
  parameter int        WIDTH     = 4,
  parameter int        DEPTH     = 2,
  parameter logic [WIDTH-1:0] START_VAL = '0,
  parameter clr_mode_e MODE      = CLR_NONE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int TAPS = DEPTH + 1;

  logic [WIDTH-1:0] tap [TAPS];

  assign tap[0] = d;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    mbit_resync_stage #(
      .WIDTH     (WIDTH),
      .START_VAL (START_VAL),
      .MODE      (MODE)
    ) u_stage (
      .clk (clk),
      .rst (rst),
      .d   (tap[s]),
      .q   (tap[s+1])
    );
  end

  assign q = tap[DEPTH];

endmodule

// File: rtl/mbit_resync.sv
module mbit_resync
  import mbit_resync_pkg::*;
#(
  parameter int   WIDTH     = 4,
  parameter int   DEPTH     = 2,
  parameter logic [WIDTH-1:0] START_VAL = '0,
  parameter bit   NO_RESET  = 1'b1
) (
  input  logic             clk_dst,
  input  logic             rst_dst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_dst
);

  localparam clr_mode_e MODE = mode_from_flag(NO_RESET);

  // R1: fewer than two stages cannot let a metastable value settle
  if (DEPTH < 2) begin : g_depth_bad
    $error("mbit_resync: DEPTH must be at least 2");
  end

  mbit_resync_chain #(
    .WIDTH     (WIDTH),
    .DEPTH     (DEPTH),
    .START_VAL (START_VAL),
    .MODE      (MODE)
  ) u_chain (
    .clk (clk_dst),
    .rst (rst_dst),
    .d   (d_async),
    .q   (q_dst)
  );

  logic primed = 1'b0;
  always_ff @(posedge clk_dst) primed <= 1'b1;

  if (!NO_RESET) begin : g_port_chk
    // R5: at the port, a reset edge shows the start value on the next cycle
    p_dout_start_r5: assert property (@(posedge clk_dst) disable iff (!primed)
      rst_dst |=> q_dst == START_VAL);
  end

endmodule

// File: tb/mbit_resync_tb.sv
module mbit_resync_tb;

  localparam int W = 4;
  localparam int D = 3;
  localparam logic [W-1:0] SV = 4'hA;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q_free;
  logic [W-1:0] q_clr;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  mbit_resync #(.WIDTH(W), .DEPTH(D), .START_VAL(SV), .NO_RESET(1'b1)) u_dut (
    .clk_dst (clk), .rst_dst (rst), .d_async (din), .q_dst (q_free));

  mbit_resync #(.WIDTH(W), .DEPTH(D), .START_VAL(SV), .NO_RESET(1'b0)) u_dut_rst (
    .clk_dst (clk), .rst_dst (rst), .d_async (din), .q_dst (q_clr));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] prev;
    #1;
    // R3: power-up value before any edge
    chk("R3 free", q_free, SV);
    chk("R3 clr", q_clr, SV);

    // initial reset: clearable instance holds start value (R5)
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5 clr", q_clr, SV);
    end
    // reset-less instance has loaded din=0 through the chain (R4)
    chk("R4 free", q_free, 4'h0);
    rst = 1'b0;
    // R6: clearable instance refills with 0 after D edges
    for (int k = 1; k <= D; k++) begin
      step();
      chk("R6 clr", q_clr, (k == D) ? 4'h0 : SV);
    end

    // R2 / R7: sweep every code through both instances
    prev = 4'h0;
    for (int v = 1; v <= 16; v++) begin
      din = W'(v);
      for (int k = 1; k <= D; k++) begin
        step();
        chk("R2 free", q_free, (k == D) ? din : prev);
        chk("R7 clr", q_clr, (k == D) ? din : prev);
      end
      prev = din;
    end

    // settle on 5
    din = 4'h5;
    for (int k = 0; k < D; k++) step();
    chk("R2 steady", q_free, 4'h5);

    // reset pulse together with a new input
    din = 4'h9;
    rst = 1'b1;
    for (int k = 1; k <= D + 1; k++) begin
      step();
      chk("R4 free", q_free, (k >= D) ? 4'h9 : 4'h5);
      chk("R5 clr", q_clr, SV);
    end
    rst = 1'b0;
    for (int k = 1; k <= D; k++) begin
      step();
      chk("R6 clr", q_clr, (k == D) ? 4'h9 : SV);
      chk("R4 free", q_free, 4'h9);
    end

    // R1: output does not change one edge early for a lone change
    din = 4'h3;
    for (int k = 1; k <= D + 1; k++) begin
      step();
      chk("R1 depth", q_clr, (k >= D) ? 4'h3 : 4'h9);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule